// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small first-level data cache placed in front of a slower memory that is organised in lines. Upstream, a single request port is shared by several requesters. Each requester is identified by an id. Each cycle the cache answers the presented request with one of three codes: WAIT, BLOCKED or OK. The cache holds one requester at a time. The first requester to reach an idle cache becomes the owner, and it keeps ownership until it receives OK.

The storage is direct-mapped. It has 32 lines of four 32-bit words, and each line carries a valid bit, a dirty bit and a tag. On a miss the cache does two things in order. First, it copies a modified victim line out to the lower memory. Then it brings in the whole requested line. For both transfers it uses the same three-code handshake, this time acting as the requester. A latency counter models the cache's own access time. The counter runs only while the owner is presenting a request that is not held up by the lower memory.

Top module: `l1_wb_cache`

## Requirements
- R1: After reset there is no owner, every line is invalid, `mem_req` is 0, and `rsp` is WAIT. The response codes are WAIT=0, BLOCKED=1, OK=2.
- R2: The request address is split as follows: word offset is bits [1:0], line index is bits [6:2], and tag is bits [19:7]. The lower-memory line address is {tag, index}, which is address bits [19:2].
- R3: A request from the owner (or from any requester when the cache is idle) gets BLOCKED while the indexed line is invalid, holds another tag, or a lower-memory transfer is in progress. One cycle after the miss is first seen, a fill starts: `mem_req`=1, `mem_we`=0, and `mem_addr` holds the requested line address.
- R4: If the victim line is valid and dirty, it is written back before the fill. During the write-back, `mem_we`=1, `mem_addr`={victim tag, index} and `mem_wline` carries the victim line. These values are held until the lower memory answers OK.
- R5: The lower memory answers OK with `mem_rsp`=2. On an OK during a write-back, the fill begins in the next cycle. On an OK during a fill, the line is installed as valid and clean, and `mem_req` drops in the next cycle.
- R6: An idle cache latches the id of the first request it sees. A request carrying any other id gets WAIT and changes no state.
- R7: The latency counter starts at DELAY. It decrements only in cycles where the owner presents a request that is not blocked. It is frozen in cycles where the request is BLOCKED or absent.
- R8: The owner gets OK in the cycle its request is not blocked and the counter is zero. Ownership is then released and the counter reloads to DELAY. A hit on a fresh access therefore completes in DELAY+1 cycles.
- R9: On a read that gets OK, `rsp_line` carries the whole line. Word k is at bits [32k+31:32k].
- R10: A write that gets OK replaces only the addressed word of its line and marks the line dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_id | input | 2 | Requester id |
| req_we | input | 1 | 1 = write one word, 0 = read a line |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write word |
| rsp | output | 2 | WAIT=0, BLOCKED=1, OK=2 |
| rsp_line | output | 128 | Line at the requested index |
| mem_req | output | 1 | Lower-memory transfer active |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | 18 | Lower-memory line address |
| mem_wline | output | 128 | Victim line data |
| mem_rsp | input | 2 | Lower-memory answer, OK=2 |
| mem_rline | input | 128 | Fill line data |

## Verification
The response code is combinational from the state and the current request, so it is due in the same cycle as the request. Lower-memory outputs change only one cycle after the event that causes them: a miss seen, a write-back accepted, or a fill accepted. Stored lines and dirty bits first affect the outputs in the cycle after an OK. The bench drives every input at the falling edge. It samples all outputs 1 ns later against a behavioural model whose state advances once per cycle. That way, every comparison lands in the cycle where the requirements place the result. Directed checks add cycle counts from the start of an access to OK, and the bench memory contents after write-back.

// File: rtl/l1_wb_cache.sv
module l1_wb_cache #(
  parameter int DW    = 32,
  parameter int OFF_W = 2,
  parameter int IDX_W = 5,
  parameter int TAG_W = 13,
  parameter int ID_W  = 2,
  parameter int DELAY = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  input  logic [ID_W-1:0]                     req_id,
  input  logic                                req_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]        req_addr,
  input  logic [DW-1:0]                       req_wdata,
  output logic [1:0]                          rsp,
  output logic [DW*(2**OFF_W)-1:0]            rsp_line,
  output logic                                mem_req,
  output logic                                mem_we,
  output logic [TAG_W+IDX_W-1:0]              mem_addr,
  output logic [DW*(2**OFF_W)-1:0]            mem_wline,
  input  logic [1:0]                          mem_rsp,
  input  logic [DW*(2**OFF_W)-1:0]            mem_rline
);
  localparam int LA_W  = TAG_W + IDX_W;
  localparam int LW    = DW * (2**OFF_W);
  localparam int LINES = 2**IDX_W;
  localparam int CNT_W = $clog2(DELAY + 2);
  localparam logic [1:0] WAIT = 2'd0, BLOCKED = 2'd1, OK = 2'd2;

  typedef enum logic [1:0] {M_IDLE, M_WB, M_FILL} mst_t;

  logic [LW-1:0]    line_q [LINES];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] vld_q, dty_q;
  logic             own_q;
  logic [ID_W-1:0]  owner_q;
  logic [CNT_W-1:0] cnt;
  mst_t             mst;
  logic [LA_W-1:0]  maddr_q;
  logic [LW-1:0]    wline;

  wire [OFF_W-1:0] off  = req_addr[OFF_W-1:0];
  wire [IDX_W-1:0] idx  = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag  = req_addr[OFF_W+IDX_W +: TAG_W];
  wire [IDX_W-1:0] midx = maddr_q[IDX_W-1:0];

  wire sel     = req_valid && (!own_q || req_id == owner_q);
  wire hit     = vld_q[idx] && (tag_q[idx] == tag);
  wire blocked = (mst != M_IDLE) || !hit;
  wire done    = sel && !blocked && (cnt == '0);
  wire mem_ok  = (mem_rsp == OK);

  assign rsp       = !sel ? WAIT : blocked ? BLOCKED : (cnt == '0) ? OK : WAIT;
  assign rsp_line  = line_q[idx];
  assign mem_req   = (mst != M_IDLE);
  assign mem_we    = (mst == M_WB);
  assign mem_addr  = mem_we ? {tag_q[midx], midx} : maddr_q;
  assign mem_wline = line_q[midx];

  always_comb begin
    wline = line_q[idx];
    wline[off*DW +: DW] = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= 1'b0;
      owner_q <= '0;
      cnt     <= CNT_W'(DELAY);
      mst     <= M_IDLE;
      maddr_q <= '0;
      vld_q   <= '0;
      dty_q   <= '0;
    end else begin
      case (mst)
        M_IDLE: if (sel && !hit) begin
          maddr_q <= {tag, idx};
          mst     <= (vld_q[idx] && dty_q[idx]) ? M_WB : M_FILL;
        end
        M_WB:   if (mem_ok) mst <= M_FILL;
        M_FILL: if (mem_ok) begin
          mst         <= M_IDLE;
          vld_q[midx] <= 1'b1;
          dty_q[midx] <= 1'b0;
        end
        default: mst <= M_IDLE;
      endcase
      if (done) begin
        own_q <= 1'b0;
        cnt   <= CNT_W'(DELAY);
        if (req_we) dty_q[idx] <= 1'b1;
      end else if (sel) begin
        own_q   <= 1'b1;
        owner_q <= req_id;
        if (!blocked && cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mst == M_FILL && mem_ok) begin
      line_q[midx] <= mem_rline;
      tag_q[midx]  <= maddr_q[IDX_W +: TAG_W];
    end else if (done && req_we) begin
      line_q[idx] <= wline;
    end
  end
endmodule

module l1_wb_cache_chk #(
  parameter int LA_W  = 18,
  parameter int CNT_W = 3,
  parameter int DELAY = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       rsp,
  input logic             mem_req,
  input logic             mem_we,
  input logic [LA_W-1:0]  mem_addr,
  input logic [1:0]       mem_rsp,
  input logic [CNT_W-1:0] cnt
);
  a_r3_no_ok_during_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> rsp != 2'd2);
  a_r4_writeback_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_rsp != 2'd2) |=> (mem_req && mem_we && $stable(mem_addr)));
  a_r5_fill_after_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_rsp == 2'd2) |=> (mem_req && !mem_we));
  a_r7_frozen_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp == 2'd1) |=> $stable(cnt));
  a_r8_reload_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp == 2'd2) |=> (cnt == CNT_W'(DELAY)));
endmodule

bind l1_wb_cache l1_wb_cache_chk #(.LA_W(LA_W), .CNT_W(CNT_W), .DELAY(DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp(rsp), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_rsp(mem_rsp), .cnt(cnt)
);

// File: tb/l1_wb_cache_bench.sv
module l1_wb_cache_bench;
  localparam int DELAY = 3;
  localparam int MLAT  = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [1:0]   req_id = '0;
  logic         req_we = 1'b0;
  logic [19:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [1:0]   rsp;
  logic [127:0] rsp_line;
  logic         mem_req, mem_we;
  logic [17:0]  mem_addr;
  logic [127:0] mem_wline;
  logic [1:0]   mem_rsp = '0;
  logic [127:0] mem_rline = '0;

  always #5 clk = ~clk;

  l1_wb_cache #(.DELAY(DELAY)) u_l1_wb_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp(rsp), .rsp_line(rsp_line),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_rsp(mem_rsp), .mem_rline(mem_rline));

  int tests = 0, fails = 0, wb_cycles = 0, mlat = 0;
  logic [127:0] bmem [int];

  bit           r_vld [32];
  bit           r_dty [32];
  int           r_tag [32];
  logic [127:0] r_line [32];
  bit           r_own = 0;
  int           r_owner = 0, r_cnt = DELAY, r_ph = 0, r_maddr = 0;

  function automatic logic [127:0] dline(int la);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = 32'hC0DE0000 ^ (la * 4 + k);
    return l;
  endfunction

  function automatic logic [127:0] mget(int la);
    return bmem.exists(la) ? bmem[la] : dline(la);
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit v, int id, bit we, logic [19:0] a, logic [31:0] wd, output logic [1:0] got);
    int idx, tg, off, mi, ersp, ela;
    bit esel, ehit, eblk, mok;
    @(negedge clk);
    req_valid = v; req_id = id[1:0]; req_we = we; req_addr = a; req_wdata = wd;
    mem_rsp   = (mem_req && mlat == MLAT) ? 2'd2 : 2'd0;
    mem_rline = mget(int'(mem_addr));
    #1;
    idx = int'(a[6:2]); tg = int'(a[19:7]); off = int'(a[1:0]); mi = r_maddr % 32;
    esel = v && (!r_own || id == r_owner);
    ehit = r_vld[idx] && r_tag[idx] == tg;
    eblk = (r_ph != 0) || !ehit;
    ersp = !esel ? 0 : eblk ? 1 : (r_cnt == 0) ? 2 : 0;
    got = rsp;
    if (ersp == 1)          check(rsp == 2'(ersp), "R3", 128'(rsp), 128'(ersp));
    else if (ersp == 2)     check(rsp == 2'(ersp), "R8", 128'(rsp), 128'(ersp));
    else if (v && !esel)    check(rsp == 2'(ersp), "R6", 128'(rsp), 128'(ersp));
    else                    check(rsp == 2'(ersp), "R7", 128'(rsp), 128'(ersp));
    check(mem_req == (r_ph != 0), "R3", 128'(mem_req), 128'(r_ph != 0));
    if (r_ph != 0) begin
      check(mem_we == (r_ph == 1), "R4", 128'(mem_we), 128'(r_ph == 1));
      ela = (r_ph == 1) ? (r_tag[mi] * 32 + mi) : r_maddr;
      check(int'(mem_addr) == ela, "R2", 128'(mem_addr), 128'(ela));
      if (r_ph == 1) check(mem_wline == r_line[mi], "R4", mem_wline, r_line[mi]);
    end
    if (ersp == 2 && !we) check(rsp_line == r_line[idx], "R9", rsp_line, r_line[idx]);
    mok = mem_req && mem_rsp == 2'd2;
    if (mem_req && mem_we) wb_cycles++;
    if (mok) begin
      if (mem_we) bmem[int'(mem_addr)] = mem_wline;
      mlat = 0;
    end else if (mem_req) mlat++;
    if (r_ph == 1 && mok) r_ph = 2;
    else if (r_ph == 2 && mok) begin
      r_line[mi] = mem_rline; r_tag[mi] = r_maddr / 32; r_vld[mi] = 1; r_dty[mi] = 0; r_ph = 0;
    end else if (r_ph == 0 && esel && !ehit) begin
      r_maddr = tg * 32 + idx;
      r_ph = (r_vld[idx] && r_dty[idx]) ? 1 : 2;
    end
    if (ersp == 2) begin
      r_own = 0; r_cnt = DELAY;
      if (we) begin r_line[idx][off*32 +: 32] = wd; r_dty[idx] = 1; end
    end else if (esel) begin
      r_own = 1; r_owner = id;
      if (!eblk && r_cnt != 0) r_cnt--;
    end
  endtask

  task automatic access(int id, bit we, logic [19:0] a, logic [31:0] wd,
                        output int cyc, output logic [127:0] line);
    logic [1:0] g;
    cyc = 0;
    do begin
      step(1, id, we, a, wd, g);
      cyc++;
      line = rsp_line;
    end while (g != 2'd2 && cyc < 60);
    step(0, 0, 0, '0, '0, g);
  endtask

  localparam logic [19:0] A = (20'd5 << 7) | (20'd3 << 2) | 20'd1;
  localparam logic [19:0] B = (20'd9 << 7) | (20'd3 << 2) | 20'd2;

  initial begin
    #(200000 * 10);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc, wb0;
    logic [127:0] ln, exp;
    logic [1:0] g;
    repeat (3) @(negedge clk);
    #1;
    check(rsp == 2'd0, "R1", 128'(rsp), 0);
    check(mem_req == 1'b0, "R1", 128'(mem_req), 0);
    rst_n = 1'b1;
    // R1 R3 R5: first access misses, fill, then DELAY+1 hit cycles
    access(0, 0, A, '0, cyc, ln);
    check(cyc == 1 + (MLAT + 1) + DELAY + 1, "R5", 128'(cyc), 128'(1 + MLAT + 1 + DELAY + 1));
    check(ln == dline(5 * 32 + 3), "R9", ln, dline(5 * 32 + 3));
    // R8 hit latency, R10 write one word
    access(1, 1, A, 32'hDEADBEEF, cyc, ln);
    check(cyc == DELAY + 1, "R8", 128'(cyc), 128'(DELAY + 1));
    access(1, 0, A + 20'd1, '0, cyc, ln);
    exp = dline(5 * 32 + 3); exp[1*32 +: 32] = 32'hDEADBEEF;
    check(ln == exp, "R10", ln, exp);
    // R4: conflicting tag evicts dirty line
    wb0 = wb_cycles;
    access(2, 0, B, '0, cyc, ln);
    check(wb_cycles - wb0 == MLAT + 1, "R4", 128'(wb_cycles - wb0), 128'(MLAT + 1));
    check(mget(5 * 32 + 3) == exp, "R4", mget(5 * 32 + 3), exp);
    check(ln == dline(9 * 32 + 3), "R2", ln, dline(9 * 32 + 3));
    // R6 R7: owner interrupted by other id and by idle cycles
    step(1, 2, 0, B, '0, g);
    step(1, 3, 1, A, 32'h1234, g);
    check(g == 2'd0, "R6", 128'(g), 0);
    step(0, 0, 0, '0, '0, g);
    step(1, 3, 0, A, '0, g);
    access(2, 0, B, '0, cyc, ln);
    check(cyc == DELAY, "R7", 128'(cyc), 128'(DELAY));
    // R4 R10: clean victim, no write-back; written word comes back from memory
    wb0 = wb_cycles;
    access(0, 0, A, '0, cyc, ln);
    check(wb_cycles == wb0, "R4", 128'(wb_cycles - wb0), 0);
    check(ln == exp, "R10", ln, exp);
    // R3: a different index misses independently
    access(3, 1, (20'd7 << 7) | (20'd20 << 2) | 20'd3, 32'hA5A5A5A5, cyc, ln);
    check(cyc == 1 + (MLAT + 1) + DELAY + 1, "R3", 128'(cyc), 128'(1 + MLAT + 1 + DELAY + 1));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule